// File: doc/BRIEF.md
# Serial Receiver with Idle Detection and Sleep/Wake Control

This block deserialises an asynchronous character stream on a multi-drop line. Every pulse of the bit-rate tick takes one sample of the line. A low sample while the receiver waits starts a character. The next eight samples are the data bits, least significant first, and the sample after them is the stop bit. At the stop sample the byte is moved to the data register and the receive-full flag is raised. A stop sample that reads low also raises the framing-error flag.

A run counter of high samples finds an idle line. In short mode every high sample counts, including data and stop bits. In long mode only high samples taken after a stop bit count. Ten consecutive counted ones (one full character time) raise the idle flag, and with the idle interrupt enabled this drives the interrupt request. Software clears the flags by strobing a status read and then a data read. Once cleared, the idle flag stays down until a new character has been received.

A node that is not addressed can put the receiver to sleep. While asleep, every flag and the interrupt are hidden, and received characters are not delivered. The receiver wakes in hardware in one of two ways, selected by the wake mode: on an idle line, or on a character whose top data bit is set. In the second case that character is delivered normally.

Top module: `uart_wake_rx`

## Requirements
- R1: On a bitTick with rxIn low while waiting, a character starts. The following 8 ticks sample data bits LSB first. On the 9th tick after the start (the stop sample) rxData takes the byte and rxFull goes high at that clock edge.
- R2: A stop sample that reads 0 sets frameErr in the same edge. The byte is still delivered and rxFull is still set.
- R3: With idleLong = 0, every high sample increments the run count and every low sample resets it, including data and stop bits. When the count reaches 10, idleFlag is set.
- R4: With idleLong = 1, only high samples taken while waiting for a start bit (after a stop bit or reset) are counted. Data and stop samples do not count.
- R5: irq is high exactly when idleFlag is high and idleIntEn is 1.
- R6: A dataRd strobe clears rxFull, idleFlag and frameErr only if a statusRd strobe came before it with no dataRd in between. A dataRd alone changes nothing.
- R7: After idleFlag has been set, it is not set again until a character sets rxFull. A long idle stretch therefore raises it only once.
- R8: While sleeping = 1, rxFull, idleFlag, frameErr and irq read 0. Characters that do not wake the receiver leave rxData and the hidden flags unchanged.
- R9: With wakeAddrMode = 0, an idle detection during sleep clears sleeping. The idle flag is not set by that detection, and the next character is delivered normally.
- R10: With wakeAddrMode = 1, a sleeping receiver wakes on a character whose bit 7 is 1 and delivers that character. Characters with bit 7 = 0 are dropped.
- R11: A sleepSet strobe sets sleeping and a sleepClr strobe clears it. When both arrive in the same cycle, set wins.
- R12: After reset, rxFull, idleFlag, frameErr, irq and sleeping are 0, rxData is 0, and the idle flag is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Serial line |
| bitTick | input | 1 | One-cycle pulse at the middle of each bit time |
| idleLong | input | 1 | 0: short idle counting, 1: count only after stop |
| idleIntEn | input | 1 | Routes the idle flag to irq |
| wakeAddrMode | input | 1 | 0: wake on idle line, 1: wake on bit 7 set |
| sleepSet | input | 1 | Software strobe, enter sleep |
| sleepClr | input | 1 | Software strobe, leave sleep |
| statusRd | input | 1 | Status register read strobe |
| dataRd | input | 1 | Data register read strobe |
| rxData | output | 8 | Last delivered byte |
| rxFull | output | 1 | Receive-full flag |
| idleFlag | output | 1 | Idle line flag |
| frameErr | output | 1 | Framing error flag |
| irq | output | 1 | Idle interrupt request |
| sleeping | output | 1 | Sleep state |

## Verification
The bench targets the all-ones character followed by a single high bit. Short counting must flag idle there, and a design that let data bits count in long mode would flag it too early. A long idle stretch is cleared mid-way to catch a flag that re-arms without a new character, and a lone data read is issued to catch a clear that ignores the read order. Sleep scenarios mix address and non-address characters with back-to-back and idle-separated traffic. A wrong wake decode shows up as a dropped or extra delivery, and a missing mask shows up as flags visible while asleep.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef enum logic [1:0] {ST_WAIT, ST_DATA, ST_STOP} rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic onesInc;
    logic onesClr;
  } dpStrobe_t;
endpackage

// File: rtl/uart_wake_dp.sv
module uart_wake_dp
  import uart_wake_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  dpStrobe_t            stb,
  output logic [DATA_BITS-1:0] shByte,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 idleHit
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0] onesCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shByte  <= '0;
      rxData  <= '0;
      onesCnt <= '0;
    end else begin
      if (stb.shiftEn) shByte <= {rxIn, shByte[DATA_BITS-1:1]};
      if (stb.loadEn)  rxData <= shByte;
      if (stb.onesClr)
        onesCnt <= '0;
      else if (stb.onesInc && onesCnt < CNT_W'(FRAME_BITS))
        onesCnt <= onesCnt + 1'b1;
    end
  end

  assign idleHit = stb.onesInc && (onesCnt == CNT_W'(FRAME_BITS - 1));
endmodule

// File: rtl/uart_wake_ctrl.sv
module uart_wake_ctrl
  import uart_wake_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 bitTick,
  input  logic                 idleLong,
  input  logic                 wakeAddrMode,
  input  logic                 sleepSet,
  input  logic                 sleepClr,
  input  logic                 statusRd,
  input  logic                 dataRd,
  input  logic [DATA_BITS-1:0] shByte,
  input  logic                 idleHit,
  output dpStrobe_t            stb,
  output logic                 fullReg,
  output logic                 idleReg,
  output logic                 errReg,
  output logic                 sleepReg
);
  localparam int BIT_W = $clog2(DATA_BITS);

  rxState_t       state;
  logic [BIT_W-1:0] bitCnt;
  logic           armed;
  logic           statusSeen;
  logic           frameDone;
  logic           addrWake;
  logic           deliver;
  logic           hwWake;
  logic           idleSetNow;
  logic           clearNow;

  always_comb begin
    frameDone  = bitTick && (state == ST_STOP);
    addrWake   = frameDone && sleepReg && wakeAddrMode && shByte[DATA_BITS-1];
    deliver    = frameDone && (!sleepReg || addrWake);
    hwWake     = addrWake || (sleepReg && !wakeAddrMode && idleHit);
    idleSetNow = idleHit && armed && !sleepReg;
    clearNow   = dataRd && statusSeen;
    stb.shiftEn = bitTick && (state == ST_DATA);
    stb.loadEn  = deliver;
    stb.onesClr = bitTick && !rxIn;
    stb.onesInc = bitTick && rxIn && (!idleLong || state == ST_WAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_WAIT;
      bitCnt <= '0;
    end else if (bitTick) begin
      unique case (state)
        ST_WAIT: if (!rxIn) begin
          state  <= ST_DATA;
          bitCnt <= '0;
        end
        ST_DATA: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == BIT_W'(DATA_BITS - 1)) state <= ST_STOP;
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullReg    <= 1'b0;
      idleReg    <= 1'b0;
      errReg     <= 1'b0;
      armed      <= 1'b1;
      statusSeen <= 1'b0;
      sleepReg   <= 1'b0;
    end else begin
      if (clearNow) begin
        fullReg <= 1'b0;
        idleReg <= 1'b0;
        errReg  <= 1'b0;
      end
      if (deliver) begin
        fullReg <= 1'b1;
        armed   <= 1'b1;
        if (!rxIn) errReg <= 1'b1;
      end
      if (idleSetNow) begin
        idleReg <= 1'b1;
        armed   <= 1'b0;
      end
      if (statusRd)    statusSeen <= 1'b1;
      else if (dataRd) statusSeen <= 1'b0;
      if (sleepSet)                sleepReg <= 1'b1;
      else if (sleepClr || hwWake) sleepReg <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uart_wake_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 bitTick,
  input  logic                 idleLong,
  input  logic                 idleIntEn,
  input  logic                 wakeAddrMode,
  input  logic                 sleepSet,
  input  logic                 sleepClr,
  input  logic                 statusRd,
  input  logic                 dataRd,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFull,
  output logic                 idleFlag,
  output logic                 frameErr,
  output logic                 irq,
  output logic                 sleeping
);
  dpStrobe_t            stb;
  logic [DATA_BITS-1:0] shByte;
  logic                 idleHit;
  logic                 fullReg, idleReg, errReg, sleepReg;

  uart_wake_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .stb(stb),
    .shByte(shByte), .rxData(rxData), .idleHit(idleHit)
  );

  uart_wake_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .bitTick(bitTick),
    .idleLong(idleLong), .wakeAddrMode(wakeAddrMode),
    .sleepSet(sleepSet), .sleepClr(sleepClr),
    .statusRd(statusRd), .dataRd(dataRd),
    .shByte(shByte), .idleHit(idleHit), .stb(stb),
    .fullReg(fullReg), .idleReg(idleReg), .errReg(errReg), .sleepReg(sleepReg)
  );

  assign sleeping = sleepReg;
  assign rxFull   = fullReg && !sleepReg;
  assign idleFlag = idleReg && !sleepReg;
  assign frameErr = errReg && !sleepReg;
  assign irq      = idleReg && idleIntEn && !sleepReg;
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic idleIntEn,
  input logic sleepSet,
  input logic sleepClr,
  input logic rxFull,
  input logic idleFlag,
  input logic frameErr,
  input logic irq,
  input logic sleeping
);
  assert_masked_asleep_R8: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |-> !(rxFull || idleFlag || frameErr || irq));

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (idleFlag && idleIntEn));

  assert_full_on_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> ($past(bitTick) || $past(sleepClr)));

  assert_idle_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleFlag) |-> ($past(bitTick) || $past(sleepClr)));

  assert_wake_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleeping) |-> ($past(bitTick) || $past(sleepClr)));

  assert_sleep_set_R11: assert property (@(posedge clk) disable iff (!rstN)
    sleepSet |=> sleeping);
endmodule

bind uart_wake_rx uart_wake_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .idleIntEn(idleIntEn),
  .sleepSet(sleepSet), .sleepClr(sleepClr), .rxFull(rxFull),
  .idleFlag(idleFlag), .frameErr(frameErr), .irq(irq), .sleeping(sleeping)
);

// File: tb/sim_uart_wake_rx.sv
`timescale 1ns/1ps
module sim_uart_wake_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1, bitTick = 1'b0, idleLong = 1'b0, idleIntEn = 1'b1;
  logic wakeAddrMode = 1'b0, sleepSet = 1'b0, sleepClr = 1'b0;
  logic statusRd = 1'b0, dataRd = 1'b0;
  logic [7:0] rxData;
  logic rxFull, idleFlag, frameErr, irq, sleeping;

  int compared = 0;
  int mismatched = 0;
  string tag = "R12";

  always #5 clk = ~clk;

  uart_wake_rx u0 (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .bitTick(bitTick),
    .idleLong(idleLong), .idleIntEn(idleIntEn), .wakeAddrMode(wakeAddrMode),
    .sleepSet(sleepSet), .sleepClr(sleepClr), .statusRd(statusRd), .dataRd(dataRd),
    .rxData(rxData), .rxFull(rxFull), .idleFlag(idleFlag), .frameErr(frameErr),
    .irq(irq), .sleeping(sleeping)
  );

  // Behavioural reference: phase 0 waits, 1..8 data bits, 9 stop sample
  int  mPhase, mOnes;
  bit  mFull, mIdle, mErr, mArmed, mSeen, mSleep;
  bit [7:0] mShift, mData;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mOnes = 0; mFull = 0; mIdle = 0; mErr = 0;
      mArmed = 1; mSeen = 0; mSleep = 0; mShift = 0; mData = 0;
    end else begin
      bit hit, done, dlv, wake, s;
      hit = 0; done = 0; s = rxIn;
      if (bitTick) begin
        if (!s) mOnes = 0;
        else if ((!idleLong || mPhase == 0) && mOnes < 10) begin
          mOnes++;
          if (mOnes == 10) hit = 1;
        end
        if (mPhase == 0) begin
          if (!s) mPhase = 1;
        end else if (mPhase <= 8) begin
          mShift[mPhase-1] = s;
          mPhase++;
        end else begin
          done = 1;
          mPhase = 0;
        end
      end
      dlv  = done && (!mSleep || (wakeAddrMode && mShift[7]));
      wake = mSleep && ((done && wakeAddrMode && mShift[7]) || (hit && !wakeAddrMode));
      if (dataRd && mSeen) begin mFull = 0; mIdle = 0; mErr = 0; end
      if (dlv) begin
        mFull = 1; mData = mShift; mArmed = 1;
        if (!s) mErr = 1;
      end
      if (hit && mArmed && !mSleep) begin mIdle = 1; mArmed = 0; end
      if (statusRd) mSeen = 1; else if (dataRd) mSeen = 0;
      if (sleepSet) mSleep = 1; else if (sleepClr || wake) mSleep = 0;
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cmp("rxData",   rxData, mData);
    cmp("rxFull",   rxFull, mFull && !mSleep);
    cmp("idleFlag", idleFlag, mIdle && !mSleep);
    cmp("frameErr", frameErr, mErr && !mSleep);
    cmp("irq",      irq, mIdle && idleIntEn && !mSleep);
    cmp("sleeping", sleeping, mSleep);
  end

  task automatic tick(input logic b);
    @(negedge clk); rxIn = b; bitTick = 1'b1;
    @(negedge clk); bitTick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  task automatic frame(input logic [7:0] d, input logic stopBit);
    tick(1'b0);
    for (int i = 0; i < 8; i++) tick(d[i]);
    tick(stopBit);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic readClear;
    pulse(statusRd);
    pulse(dataRd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;                         // R12 reset values compared above
    tag = "R3"; ones(12);                // short idle after reset, R5 irq
    tag = "R6"; readClear();
    tag = "R1"; frame(8'h5A, 1'b1); ones(1);
    tag = "R6"; pulse(dataRd); repeat (3) @(negedge clk); readClear();
    tag = "R2"; frame(8'hC3, 1'b0); ones(2); readClear();
    tag = "R3"; frame(8'hFF, 1'b1); ones(1); readClear();
    tag = "R7"; ones(25); readClear(); ones(15);
    frame(8'h11, 1'b1); ones(12); readClear();
    idleIntEn = 1'b0;
    tag = "R5"; frame(8'h01, 1'b1); ones(11); readClear();
    idleIntEn = 1'b1;
    tag = "R4"; idleLong = 1'b1; frame(8'hFF, 1'b1); ones(5); readClear();
    ones(6); readClear(); frame(8'hA5, 1'b1); ones(10); readClear();
    idleLong = 1'b0;
    tag = "R8"; pulse(sleepSet); frame(8'h3C, 1'b1); frame(8'h66, 1'b0);
    tag = "R9"; ones(10); frame(8'h42, 1'b1); ones(1); readClear();
    tag = "R10"; wakeAddrMode = 1'b1; frame(8'h00, 1'b1); ones(1); pulse(sleepSet);
    frame(8'h12, 1'b1); ones(12); frame(8'h85, 1'b1); ones(2); readClear();
    tag = "R11"; pulse(sleepSet); frame(8'h9F, 1'b0); ones(3); pulse(sleepClr);
    readClear();
    @(negedge clk); sleepSet = 1'b1; sleepClr = 1'b1;
    @(negedge clk); sleepSet = 1'b0; sleepClr = 1'b0;
    frame(8'h07, 1'b1); pulse(sleepClr); ones(12); readClear();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule